// File: doc/BRIEF.md
# Four-Pin GPIO Port with Analog Select and Reset-Pin Mux

This block is a small general-purpose I/O port sitting on a simple synchronous register bus. Pins 0 to 2 are bidirectional. Each has a direction bit and an output latch bit, and an analog-select bit hands the pin to a converter input by blanking its digital read path. Pin 3 is input-only. It shares its pad with an external master-clear function. A static configuration input decides whether pin 3 raises an active-low reset request or shows up as a plain port bit.

Every pad input goes through a two-flop synchronizer before software can read it. Software reads port data through address 0, and writing address 0 or address 1 updates the output latch. Address 1 reads back the latch, address 2 holds the direction bits, and addresses 3 and 4 hold the analog-select bits. Reads are combinational from the current register and synchronizer state. Writes take effect at the rising clock edge on which `bus_we` is sampled high.

Top module: `gpio_anport`

## Requirements
- R1: Direction register (address 2, bits 2:0, reset 3'b111). A bit of 0 drives `pad_oe` high for that pin and a bit of 1 drives it low. `pad_oe` and readback change one edge after the write.
- R2: A write to address 0 or address 1 loads bits 2:0 into the output latch, which resets to 0. `pad_out[2:0]` shows the latch one edge after the write. A read of address 1 returns the latch contents, not the pad levels.
- R3: While a pin's analog-select bit is 1, its bit in the address-0 read is 0. The bit does not change `pad_oe` or `pad_out` for that pin.
- R4: The analog-select bits reset to 1. Pins 0 and 1 map to bits 6 and 7 of address 3. Pin 2 maps to bit 0 of address 4.
- R5: Pin 3 is never driven: `pad_oe[3]` and `pad_out[3]` are always 0.
- R6: With `cfg_mclr_en` = 1, `mclr_req_n` follows the synchronized pin-3 level and bit 3 of the address-0 read is 0. With `cfg_mclr_en` = 0, `mclr_req_n` is 1 and bit 3 shows the synchronized pin-3 level.
- R7: A pad change shows in the address-0 read after the second rising edge, not the first. The synchronizer resets to all ones.
- R8: Unimplemented bits read as 0. This covers address 0 bits 7:4, addresses 1 and 2 bits 7:3, address 3 bits 5:0, address 4 bits 7:1, and all of addresses 5 to 7.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | 3 | Register address |
| bus_we | input | 1 | Write strobe, sampled at the rising edge |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Combinational read data for `bus_addr` |
| cfg_mclr_en | input | 1 | Static: 1 makes pin 3 a master-clear input |
| pad_in | input | 4 | Pad input levels, asynchronous |
| pad_oe | output | 4 | Per-pin output enable to the pad cells |
| pad_out | output | 4 | Per-pin output data to the pad cells |
| mclr_req_n | output | 1 | Active-low external reset request |

## Verification
Two events can land on the same rising edge: a write that clears an analog-select bit, and the second synchronizer stage taking in a new pad level. The bench provokes this by changing pin 0 on one falling edge and issuing the select write on the next one. Both therefore commit on the same rising edge. The port read taken on the falling edge right after that edge must already show the new pin level ungated. Earlier reads check that a pad change is still hidden after one edge and that analog gating masks it.

// File: rtl/gpio_anport_pkg.sv
package gpio_anport_pkg;
   localparam int unsigned ADDR_W = 3;

   typedef enum logic [ADDR_W-1:0] {
      RA_PORT = 3'd0,
      RA_LAT  = 3'd1,
      RA_DIR  = 3'd2,
      RA_SELA = 3'd3,
      RA_SELB = 3'd4
   } reg_addr_e;
endpackage

// File: rtl/gpio_anport_sync.sv
module gpio_anport_sync #(
   parameter int unsigned W       = 4,
   parameter int unsigned STAGES  = 2,
   parameter logic [W-1:0] RST_VAL = '1
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] d,
   output logic [W-1:0] q
);
   if (STAGES < 2) begin : g_bad_stages
      $error("gpio_anport_sync: STAGES must be at least 2");
   end

   logic [W-1:0] stage_q [STAGES];

   for (genvar s = 0; s < STAGES; s++) begin : g_stage
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)
            stage_q[s] <= RST_VAL;
         else if (s == 0)
            stage_q[s] <= d;
         else
            stage_q[s] <= stage_q[(s == 0) ? 0 : s-1];
      end
   end

   assign q = stage_q[STAGES-1];
endmodule

// File: rtl/gpio_anport_regs.sv
module gpio_anport_regs
   import gpio_anport_pkg::*;
#(
   parameter int unsigned DATA_W   = 8,
   parameter int unsigned NBIDIR   = 3,
   parameter int unsigned SELA_LSB = 6
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [ADDR_W-1:0] addr,
   input  logic              we,
   input  logic [DATA_W-1:0] wdata,
   output logic [NBIDIR-1:0] lat,
   output logic [NBIDIR-1:0] dir,
   output logic [NBIDIR-1:0] ana
);
   logic wr_lat, wr_dir, wr_sela, wr_selb;
   logic unused_wdata;

   assign wr_lat  = we && (addr == RA_PORT || addr == RA_LAT);
   assign wr_dir  = we && (addr == RA_DIR);
   assign wr_sela = we && (addr == RA_SELA);
   assign wr_selb = we && (addr == RA_SELB);
   assign unused_wdata = ^wdata;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         lat <= '0;
      else if (wr_lat)
         lat <= wdata[NBIDIR-1:0];
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         dir <= '1;
      else if (wr_dir)
         dir <= wdata[NBIDIR-1:0];
   end

   for (genvar i = 0; i < NBIDIR; i++) begin : g_ana
      localparam int unsigned POS = SELA_LSB + i;
      if (POS < DATA_W) begin : g_in_a
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)
               ana[i] <= 1'b1;
            else if (wr_sela)
               ana[i] <= wdata[POS];
         end
      end else begin : g_in_b
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)
               ana[i] <= 1'b1;
            else if (wr_selb)
               ana[i] <= wdata[POS-DATA_W];
         end
      end
   end
endmodule

// File: rtl/gpio_anport_rdmux.sv
module gpio_anport_rdmux
   import gpio_anport_pkg::*;
#(
   parameter int unsigned DATA_W   = 8,
   parameter int unsigned NBIDIR   = 3,
   parameter int unsigned SELA_LSB = 6
) (
   input  logic [ADDR_W-1:0] addr,
   input  logic [NBIDIR-1:0] lat,
   input  logic [NBIDIR-1:0] dir,
   input  logic [NBIDIR-1:0] ana,
   input  logic [NBIDIR:0]   pin_sync,
   input  logic              mclr_en,
   output logic [DATA_W-1:0] rdata
);
   logic [DATA_W-1:0] port_img, lat_img, dir_img, sela_img, selb_img;

   for (genvar b = 0; b < DATA_W; b++) begin : g_img
      if (b < NBIDIR) begin : g_bidir
         assign port_img[b] = pin_sync[b] & ~ana[b];
         assign lat_img[b]  = lat[b];
         assign dir_img[b]  = dir[b];
      end else if (b == NBIDIR) begin : g_inonly
         assign port_img[b] = pin_sync[b] & ~mclr_en;
         assign lat_img[b]  = 1'b0;
         assign dir_img[b]  = 1'b0;
      end else begin : g_none
         assign port_img[b] = 1'b0;
         assign lat_img[b]  = 1'b0;
         assign dir_img[b]  = 1'b0;
      end
      if (b >= SELA_LSB && b - SELA_LSB < NBIDIR) begin : g_sa
         assign sela_img[b] = ana[b-SELA_LSB];
      end else begin : g_sa0
         assign sela_img[b] = 1'b0;
      end
      if (b + DATA_W >= SELA_LSB && b + DATA_W - SELA_LSB < NBIDIR) begin : g_sb
         assign selb_img[b] = ana[b+DATA_W-SELA_LSB];
      end else begin : g_sb0
         assign selb_img[b] = 1'b0;
      end
   end

   always_comb begin
      unique case (addr)
         RA_PORT: rdata = port_img;
         RA_LAT:  rdata = lat_img;
         RA_DIR:  rdata = dir_img;
         RA_SELA: rdata = sela_img;
         RA_SELB: rdata = selb_img;
         default: rdata = '0;
      endcase
   end
endmodule

// File: rtl/gpio_anport.sv
module gpio_anport
   import gpio_anport_pkg::*;
#(
   parameter int unsigned DATA_W      = 8,
   parameter int unsigned NBIDIR      = 3,
   parameter int unsigned SELA_LSB    = 6,
   parameter int unsigned SYNC_STAGES = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic              bus_we,
   input  logic [DATA_W-1:0] bus_wdata,
   output logic [DATA_W-1:0] bus_rdata,
   input  logic              cfg_mclr_en,
   input  logic [NBIDIR:0]   pad_in,
   output logic [NBIDIR:0]   pad_oe,
   output logic [NBIDIR:0]   pad_out,
   output logic              mclr_req_n
);
   localparam int unsigned NPAD = NBIDIR + 1;

   if (NPAD > DATA_W) begin : g_bad_width
      $error("gpio_anport: port does not fit the data width");
   end
   if (SELA_LSB + NBIDIR > 2 * DATA_W) begin : g_bad_sel
      $error("gpio_anport: analog-select bits exceed two registers");
   end

   logic [NBIDIR-1:0] lat, dir, ana;
   logic [NPAD-1:0]   pin_sync;

   gpio_anport_sync #(.W(NPAD), .STAGES(SYNC_STAGES), .RST_VAL('1)) u_sync (
      .clk(clk), .rst_n(rst_n), .d(pad_in), .q(pin_sync)
   );

   gpio_anport_regs #(.DATA_W(DATA_W), .NBIDIR(NBIDIR), .SELA_LSB(SELA_LSB)) u_regs (
      .clk(clk), .rst_n(rst_n), .addr(bus_addr), .we(bus_we), .wdata(bus_wdata),
      .lat(lat), .dir(dir), .ana(ana)
   );

   gpio_anport_rdmux #(.DATA_W(DATA_W), .NBIDIR(NBIDIR), .SELA_LSB(SELA_LSB)) u_rdmux (
      .addr(bus_addr), .lat(lat), .dir(dir), .ana(ana), .pin_sync(pin_sync),
      .mclr_en(cfg_mclr_en), .rdata(bus_rdata)
   );

   assign pad_oe     = {1'b0, ~dir};
   assign pad_out    = {1'b0, lat};
   assign mclr_req_n = cfg_mclr_en ? pin_sync[NBIDIR] : 1'b1;
endmodule

// File: rtl/gpio_anport_chk.sv
module gpio_anport_chk
   import gpio_anport_pkg::*;
#(
   parameter int unsigned DATA_W = 8,
   parameter int unsigned NBIDIR = 3
) (
   input logic              clk,
   input logic              rst_n,
   input logic [ADDR_W-1:0] bus_addr,
   input logic              bus_we,
   input logic [DATA_W-1:0] bus_wdata,
   input logic [DATA_W-1:0] bus_rdata,
   input logic              cfg_mclr_en,
   input logic [NBIDIR:0]   pad_oe,
   input logic [NBIDIR:0]   pad_out,
   input logic              mclr_req_n,
   input logic [NBIDIR-1:0] ana
);
   a_r1_oe_after_dir_write: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_we && bus_addr == RA_DIR) |=> (pad_oe[NBIDIR-1:0] == ~$past(bus_wdata[NBIDIR-1:0])));

   a_r2_out_after_lat_write: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_we && (bus_addr == RA_LAT || bus_addr == RA_PORT))
      |=> (pad_out[NBIDIR-1:0] == $past(bus_wdata[NBIDIR-1:0])));

   a_r3_analog_gates_read: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_addr == RA_PORT) |-> ((bus_rdata[NBIDIR-1:0] & ana) == '0));

   a_r5_pin3_undriven: assert property (@(posedge clk) disable iff (!rst_n)
      !pad_oe[NBIDIR] && !pad_out[NBIDIR]);

   a_r6_mclr_idle: assert property (@(posedge clk) disable iff (!rst_n)
      !cfg_mclr_en |-> mclr_req_n);

   a_r6_bit3_masked: assert property (@(posedge clk) disable iff (!rst_n)
      (cfg_mclr_en && bus_addr == RA_PORT) |-> !bus_rdata[NBIDIR]);

   a_r8_port_upper_zero: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_addr == RA_PORT) |-> (bus_rdata[DATA_W-1:NBIDIR+1] == '0));
endmodule

bind gpio_anport gpio_anport_chk #(.DATA_W(DATA_W), .NBIDIR(NBIDIR)) u_chk (.*);

// File: tb/gpio_anport_tb.sv
`timescale 1ns/1ps
module gpio_anport_tb;
   import gpio_anport_pkg::*;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic [2:0] bus_addr = '0;
   logic       bus_we = 1'b0;
   logic [7:0] bus_wdata = '0;
   logic [7:0] bus_rdata;
   logic       cfg_mclr_en = 1'b0;
   logic [3:0] pad_in = 4'b1111;
   logic [3:0] pad_oe, pad_out;
   logic       mclr_req_n;

   localparam int S_RD = 0, S_OE = 1, S_OUT = 2, S_MCLR = 3;

   typedef struct {
      int         sel;
      logic [7:0] exp;
      string      tag;
   } item_t;

   item_t q[$];
   int n_cmp = 0, n_bad = 0;
   bit done = 0;

   always #2 clk = ~clk;

   gpio_anport u_dut (
      .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_we(bus_we),
      .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .cfg_mclr_en(cfg_mclr_en),
      .pad_in(pad_in), .pad_oe(pad_oe), .pad_out(pad_out), .mclr_req_n(mclr_req_n)
   );

   // monitor: pops expected items one time unit after the falling edge
   initial begin
      forever begin
         @(negedge clk);
         #1;
         while (q.size() > 0) begin
            item_t it;
            logic [7:0] act;
            it = q.pop_front();
            case (it.sel)
               S_RD:    act = bus_rdata;
               S_OE:    act = {4'b0, pad_oe};
               S_OUT:   act = {4'b0, pad_out};
               default: act = {7'b0, mclr_req_n};
            endcase
            n_cmp++;
            if (act !== it.exp) begin
               n_bad++;
               $display("FAIL %s: actual %02h expected %02h", it.tag, act, it.exp);
            end
         end
      end
   end

   task automatic push(input int sel, input logic [7:0] exp, input string tag);
      item_t it;
      it.sel = sel; it.exp = exp; it.tag = tag;
      q.push_back(it);
   endtask

   task automatic chk(input int sel, input logic [2:0] a, input logic [7:0] exp, input string tag);
      @(negedge clk);
      bus_addr = a;
      push(sel, exp, tag);
   endtask

   task automatic wr(input logic [2:0] a, input logic [7:0] d);
      @(negedge clk);
      bus_we = 1'b1; bus_addr = a; bus_wdata = d;
      @(negedge clk);
      bus_we = 1'b0;
   endtask

   task automatic set_pad(input logic [3:0] v);
      @(negedge clk);
      pad_in = v;
      @(posedge clk);
      @(posedge clk);
   endtask

   initial begin
      #(4 * 200000);
      if (!done) begin
         n_cmp++; n_bad++;
         $display("FAIL watchdog: actual hung expected finish");
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
         $finish;
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      // reset state
      chk(S_RD, RA_PORT, 8'h08, "R4 reset port read gated");
      chk(S_RD, RA_DIR,  8'h07, "R1 reset direction");
      chk(S_RD, RA_LAT,  8'h00, "R2 reset latch");
      chk(S_RD, RA_SELA, 8'hC0, "R4 reset select A");
      chk(S_RD, RA_SELB, 8'h01, "R4 reset select B");
      chk(S_OE, RA_PORT, 8'h00, "R1 reset oe");
      chk(S_OUT, RA_PORT, 8'h00, "R5 reset out");
      chk(S_MCLR, RA_PORT, 8'h01, "R6 reset mclr idle");
      chk(S_RD, 3'd5, 8'h00, "R8 unused address 5");
      // analog gating per select bit
      wr(RA_SELA, 8'h00);
      chk(S_RD, RA_PORT, 8'h0B, "R3 pins0,1 digital");
      wr(RA_SELB, 8'h00);
      chk(S_RD, RA_PORT, 8'h0F, "R3 all digital");
      wr(RA_SELA, 8'hFF);
      chk(S_RD, RA_SELA, 8'hC0, "R8 select A unimplemented bits");
      chk(S_RD, RA_PORT, 8'h0C, "R4 bits6,7 gate pins0,1");
      wr(RA_SELB, 8'hFF);
      chk(S_RD, RA_SELB, 8'h01, "R8 select B unimplemented bits");
      chk(S_RD, RA_PORT, 8'h08, "R4 bit0 of B gates pin2");
      wr(RA_SELB, 8'h00);
      wr(RA_SELA, 8'h00);
      // latch and direction
      wr(RA_PORT, 8'hFF);
      chk(S_RD, RA_LAT, 8'h07, "R2 port-address write loads latch");
      chk(S_OUT, RA_PORT, 8'h07, "R2 pad_out follows latch");
      chk(S_OE, RA_PORT, 8'h00, "R1 inputs not driven");
      wr(RA_DIR, 8'h02);
      chk(S_OE, RA_PORT, 8'h05, "R1 dir 0 enables output");
      chk(S_RD, RA_DIR, 8'h02, "R1 direction readback");
      wr(RA_LAT, 8'h05);
      chk(S_RD, RA_LAT, 8'h05, "R2 latch read not pads");
      chk(S_RD, RA_PORT, 8'h0F, "R2 port read shows pads");
      chk(S_OUT, RA_PORT, 8'h05, "R2 pad_out after latch write");
      // analog does not disturb output path
      wr(RA_SELA, 8'hC0);
      chk(S_OE, RA_PORT, 8'h05, "R3 analog keeps oe");
      chk(S_OUT, RA_PORT, 8'h05, "R3 analog keeps out");
      chk(S_RD, RA_PORT, 8'h0C, "R3 analog gates read");
      // synchronizer latency
      @(negedge clk);
      pad_in = 4'b0000;
      chk(S_RD, RA_PORT, 8'h0C, "R7 hidden after one edge");
      chk(S_RD, RA_PORT, 8'h00, "R7 visible after two edges");
      // master-clear mux
      @(negedge clk);
      cfg_mclr_en = 1'b1;
      chk(S_MCLR, RA_PORT, 8'h00, "R6 mclr asserted pad low");
      set_pad(4'b1111);
      chk(S_MCLR, RA_PORT, 8'h01, "R6 mclr released pad high");
      chk(S_RD, RA_PORT, 8'h04, "R6 bit3 masked in mclr mode");
      set_pad(4'b0111);
      chk(S_MCLR, RA_PORT, 8'h00, "R6 mclr follows pin3");
      @(negedge clk);
      cfg_mclr_en = 1'b0;
      chk(S_MCLR, RA_PORT, 8'h01, "R6 mclr idle when disabled");
      set_pad(4'b1111);
      chk(S_RD, RA_PORT, 8'h0C, "R6 bit3 visible when disabled");
      // pin 3 never driven
      wr(RA_DIR, 8'h00);
      chk(S_OE, RA_PORT, 8'h07, "R5 oe3 stays low");
      wr(RA_LAT, 8'hFF);
      chk(S_OUT, RA_PORT, 8'h07, "R5 out3 stays low");
      wr(RA_DIR, 8'hFF);
      chk(S_RD, RA_DIR, 8'h07, "R8 direction upper bits");
      chk(S_RD, 3'd6, 8'h00, "R8 unused address 6");
      // select write and synchronizer delivery on the same edge
      set_pad(4'b0000);
      @(negedge clk);
      pad_in = 4'b0001;
      @(negedge clk);
      bus_we = 1'b1; bus_addr = RA_SELA; bus_wdata = 8'h00;
      @(negedge clk);
      bus_we = 1'b0; bus_addr = RA_PORT;
      push(S_RD, 8'h01, "R3 R7 select clear and pad arrive together");
      repeat (3) @(negedge clk);
      done = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end
endmodule